// File: doc/BRIEF.md
# Timestamping transmit frame buffer

This block keeps up to eight prepared time-synchronisation frames in a two-port byte memory. Each section holds the frame, a length byte and a four-byte timestamp slot. Software reads and writes any byte through a plain address/data port. It asks for frames by pulsing a request strobe with a mask of buffer bits. The block sends the frames one at a time, lowest buffer index first, as a byte stream with valid/ready handshaking toward a transmit MAC.

When a frame is taken for sending, the block samples the real-time-clock input. It streams the stored frame bytes. Once the final byte has been accepted, it writes the sampled clock value into the frame's timestamp slot. Only after that does it pulse the completion interrupt, and it reports which buffer was sent. A waiting mask shows which requested buffers are still outstanding. Padding, CRC and the clock itself belong to neighbouring logic.

Back-pressure rules on the stream: a byte is transferred only on a cycle where both `tx_valid` and `tx_ready` are high. While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values. `tx_valid` never drops before the byte flagged with `tx_last` has been accepted.

Top module: `tsf_tx_buffer`

## Requirements
- R1: After reset, `waiting` is all zeros, and `irq` and `tx_valid` are low.
- R2: Every byte of the memory can be written and read from the software port. The address is {buffer index, byte offset}, with the offset in the low 8 bits. Read data appears on `sw_rdata` one clock after `sw_rd` is sampled.
- R3: A `req_wr` pulse ORs `req_bits` into `waiting`. A buffer's bit clears on the edge that ends its `irq` cycle, unless that buffer was requested again while it was in flight.
- R4: When several bits are waiting, the lowest-numbered buffer is sent first.
- R5: A frame consists of the bytes at offsets 8 onward, in ascending order, for as many bytes as the length byte at offset 0 gives. Offsets 1 to 7 are never sent.
- R6: A byte advances only when `tx_ready` is high. Data and `tx_last` stay stable while the stream is stalled. `tx_last` is high on the final byte only.
- R7: A length of 0 sends no bytes but still completes with timestamp writeback and `irq`. A length above 244 is cut to 244 bytes.
- R8: The `rtc_in` value is sampled on the edge where a buffer is taken for sending. After the last byte, it is written most significant byte first into offsets 0xFC to 0xFF, and this finishes before `irq` is raised.
- R9: `irq` is a single-cycle pulse per completed frame. `last_sent` already holds the sent buffer's index in that cycle.
- R10: A software write into the section being sent is dropped. This holds from the edge that starts the frame through its `irq` cycle. Writes to other sections still take effect.
- R11: If a buffer is requested again while it is in flight, it stays waiting and is sent once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Software byte write strobe |
| sw_rd | input | 1 | Software byte read strobe |
| sw_addr | input | 11 | Software byte address {buffer, offset} |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Software read data, one cycle after `sw_rd` |
| req_wr | input | 1 | Request strobe |
| req_bits | input | 8 | Buffers to request, one bit each |
| rtc_in | input | 32 | Real-time-clock value |
| waiting | output | 8 | Requested buffers not yet completed |
| last_sent | output | 3 | Index of the most recently completed buffer |
| irq | output | 1 | Completion pulse |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
The timing budget is as follows:
- A read returns data one clock after its strobe.
- A request taken on edge N starts the frame on edge N+1, which is also when `rtc_in` is sampled.
- The first byte is valid after edge N+2.
- `irq` appears five clocks after the final accepted byte: four writeback cycles and then the pulse.
- The waiting bit updates one clock after `irq`.

The bench drives every input just after a falling edge and samples every output at the following falling edge. It counts cycles only where the budget above fixes them. Otherwise it follows the stream handshake byte by byte, so varied ready patterns cannot shift a sample onto the wrong cycle. The real-time-clock input is changed on the first streamed byte. The stored stamp must therefore equal the value present when the frame started.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEN,
    ST_SEND,
    ST_WB,
    ST_DONE
  } eng_state_t;
endpackage

// File: rtl/tsf_mem.sv
module tsf_mem #(
  parameter int NSEC      = 8,
  parameter int SEC_BYTES = 256,
  localparam int DEPTH    = NSEC * SEC_BYTES,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  // software side, registered read
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  // engine side, combinational read
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [7:0]    b_wdata,
  output logic [7:0]    b_rdata
);
  logic [7:0] ram [DEPTH];

  // engine write is last, so it wins on an address clash
  always_ff @(posedge clk) begin
    if (a_we) ram[a_addr] <= a_wdata;
    if (b_we) ram[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    a_rdata <= '0;
    else if (a_re) a_rdata <= ram[a_addr];
  end

  assign b_rdata = ram[b_addr];
endmodule

// File: rtl/tsf_arbiter.sv
module tsf_arbiter #(
  parameter int NSEC = 8,
  localparam int IW  = $clog2(NSEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_wr,
  input  logic [NSEC-1:0] req_bits,
  input  logic            eng_busy,
  input  logic [IW-1:0]   eng_idx,
  input  logic            done,
  output logic [NSEC-1:0] waiting,
  output logic            start,
  output logic [IW-1:0]   start_idx
);
  logic            again;
  logic [NSEC-1:0] wait_nxt;
  logic            req_cur;

  assign req_cur = req_wr && req_bits[eng_idx];

  always_comb begin
    wait_nxt = waiting | (req_wr ? req_bits : '0);
    if (done) wait_nxt[eng_idx] = again || req_cur;
  end

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    start_idx = '0;
    for (int i = NSEC - 1; i >= 0; i--) begin
      if (waiting[i]) start_idx = IW'(i);
    end
  end

  assign start = !eng_busy && (|waiting);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting <= '0;
      again   <= 1'b0;
    end else begin
      waiting <= wait_nxt;
      if (start || done)               again <= 1'b0;
      else if (eng_busy && req_cur)    again <= 1'b1;
    end
  end

  assert_grant_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (waiting[start_idx] && ((waiting & ((NSEC'(1) << start_idx) - NSEC'(1))) == '0)));

  assert_done_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !again && !req_cur) |=> !waiting[$past(eng_idx)]);

  assert_requeue_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && again) |=> waiting[$past(eng_idx)]);
endmodule

// File: rtl/tsf_engine.sv
module tsf_engine
  import tsf_pkg::*;
#(
  parameter int NSEC      = 8,
  parameter int SEC_BYTES = 256,
  parameter int HDR_BYTES = 8,
  parameter int MAX_LEN   = 244,
  parameter int RTC_W     = 32,
  localparam int IW       = $clog2(NSEC),
  localparam int OW       = $clog2(SEC_BYTES),
  localparam int TSB      = RTC_W / 8,
  localparam int WBW      = $clog2(TSB),
  localparam int TS_OFS   = SEC_BYTES - TSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IW-1:0]    start_idx,
  input  logic [RTC_W-1:0] rtc_in,
  output logic [IW+OW-1:0] mem_addr,
  output logic             mem_we,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             tx_ready,
  output logic             busy,
  output logic [IW-1:0]    cur_idx,
  output logic             done,
  output logic [IW-1:0]    last_sent
);
  eng_state_t       st;
  logic [RTC_W-1:0] ts;
  logic [OW-1:0]    len;
  logic [OW-1:0]    cnt;
  logic [WBW-1:0]   wbc;
  logic [OW-1:0]    ofs;
  logic [OW-1:0]    len_c;
  logic             at_end;

  assign len_c  = (mem_rdata > 8'(MAX_LEN)) ? OW'(MAX_LEN) : OW'(mem_rdata);
  assign at_end = (cnt == len - OW'(1));

  always_comb begin
    unique case (st)
      ST_SEND: ofs = OW'(HDR_BYTES) + cnt;
      ST_WB:   ofs = OW'(TS_OFS) + OW'(wbc);
      default: ofs = '0;
    endcase
  end

  always_comb begin
    mem_wdata = '0;
    for (int j = 0; j < TSB; j++) begin
      if (wbc == WBW'(j)) mem_wdata = ts[RTC_W-1-8*j -: 8];
    end
  end

  assign mem_addr = {cur_idx, ofs};
  assign mem_we   = (st == ST_WB);
  assign tx_valid = (st == ST_SEND);
  assign tx_data  = mem_rdata;
  assign tx_last  = tx_valid && at_end;
  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_idx   <= '0;
      ts        <= '0;
      len       <= '0;
      cnt       <= '0;
      wbc       <= '0;
      last_sent <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          cur_idx <= start_idx;
          ts      <= rtc_in;
          st      <= ST_LEN;
        end
        ST_LEN: begin
          len <= len_c;
          cnt <= '0;
          wbc <= '0;
          st  <= (len_c == '0) ? ST_WB : ST_SEND;
        end
        ST_SEND: if (tx_ready) begin
          if (at_end) st <= ST_WB;
          else        cnt <= cnt + OW'(1);
        end
        ST_WB: begin
          wbc <= wbc + WBW'(1);
          if (wbc == WBW'(TSB - 1)) begin
            st        <= ST_DONE;
            last_sent <= cur_idx;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  assert_last_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_stamp_before_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_we));

  assert_frame_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (cnt < OW'(MAX_LEN)));
endmodule

// File: rtl/tsf_tx_buffer.sv
module tsf_tx_buffer #(
  parameter int NUM_BUF   = 8,
  parameter int SEC_BYTES = 256,
  parameter int HDR_BYTES = 8,
  parameter int MAX_LEN   = 244,
  parameter int RTC_W     = 32,
  localparam int IW       = $clog2(NUM_BUF),
  localparam int OW       = $clog2(SEC_BYTES),
  localparam int AW       = IW + OW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_wr,
  input  logic               sw_rd,
  input  logic [AW-1:0]      sw_addr,
  input  logic [7:0]         sw_wdata,
  output logic [7:0]         sw_rdata,
  input  logic               req_wr,
  input  logic [NUM_BUF-1:0] req_bits,
  input  logic [RTC_W-1:0]   rtc_in,
  output logic [NUM_BUF-1:0] waiting,
  output logic [IW-1:0]      last_sent,
  output logic               irq,
  output logic               tx_valid,
  output logic [7:0]         tx_data,
  output logic               tx_last,
  input  logic               tx_ready
);
  logic          start;
  logic [IW-1:0] start_idx;
  logic          busy;
  logic [IW-1:0] cur_idx;
  logic [AW-1:0] e_addr;
  logic          e_we;
  logic [7:0]    e_wdata;
  logic [7:0]    e_rdata;
  logic          sw_hit;
  logic          sw_we_ok;

  // software writes into the section in flight are dropped
  assign sw_hit   = busy && (sw_addr[AW-1:OW] == cur_idx);
  assign sw_we_ok = sw_wr && !sw_hit;

  tsf_mem #(.NSEC(NUM_BUF), .SEC_BYTES(SEC_BYTES)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_we   (sw_we_ok),
    .a_re   (sw_rd),
    .a_addr (sw_addr),
    .a_wdata(sw_wdata),
    .a_rdata(sw_rdata),
    .b_we   (e_we),
    .b_addr (e_addr),
    .b_wdata(e_wdata),
    .b_rdata(e_rdata)
  );

  tsf_arbiter #(.NSEC(NUM_BUF)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_wr   (req_wr),
    .req_bits (req_bits),
    .eng_busy (busy),
    .eng_idx  (cur_idx),
    .done     (irq),
    .waiting  (waiting),
    .start    (start),
    .start_idx(start_idx)
  );

  tsf_engine #(
    .NSEC(NUM_BUF), .SEC_BYTES(SEC_BYTES), .HDR_BYTES(HDR_BYTES),
    .MAX_LEN(MAX_LEN), .RTC_W(RTC_W)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_idx(start_idx),
    .rtc_in   (rtc_in),
    .mem_addr (e_addr),
    .mem_we   (e_we),
    .mem_wdata(e_wdata),
    .mem_rdata(e_rdata),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .tx_ready (tx_ready),
    .busy     (busy),
    .cur_idx  (cur_idx),
    .done     (irq),
    .last_sent(last_sent)
  );

  assert_irq_quiet_stream_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !tx_valid);
endmodule

// File: tb/tsf_tx_buffer_bench.sv
module tsf_tx_buffer_bench;
  localparam int NB = 8;
  localparam int SB = 256;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sw_wr, sw_rd;
  logic [AW-1:0] sw_addr;
  logic [7:0]    sw_wdata, sw_rdata;
  logic          req_wr;
  logic [NB-1:0] req_bits;
  logic [31:0]   rtc_in;
  logic [NB-1:0] waiting;
  logic [2:0]    last_sent;
  logic          irq, tx_valid, tx_last, tx_ready;
  logic [7:0]    tx_data;

  always #5 clk = ~clk;

  tsf_tx_buffer u_tsf_tx_buffer (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .req_wr(req_wr), .req_bits(req_bits),
    .rtc_in(rtc_in), .waiting(waiting), .last_sent(last_sent), .irq(irq),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  int         checks = 0;
  int         fails  = 0;
  int         tseq   = 0;
  logic [7:0] exp_mem [NB*SB];
  int         lens [NB];

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int b, input int o);
    return 8'(b * 37 + o * 11 + 5);
  endfunction

  function automatic logic [31:0] vts(input int s);
    return 32'hC05A003C + (32'(s) << 24) + (32'(s) << 8);
  endfunction

  function automatic int eff_len(input int b);
    return (lens[b] > 244) ? 244 : lens[b];
  endfunction

  function automatic int lowest(input logic [NB-1:0] m);
    for (int i = 0; i < NB; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic sw_write(input int a, input logic [7:0] d);
    sw_wr = 1'b1; sw_addr = AW'(a); sw_wdata = d;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic sw_read(input int a, output logic [7:0] v);
    sw_rd = 1'b1; sw_addr = AW'(a);
    @(negedge clk);
    sw_rd = 1'b0;
    v = sw_rdata;
  endtask

  // pmode: 0 none, 1 writes during first frame (R10), 2 re-request first frame (R11)
  task automatic run_batch(input logic [NB-1:0] mask, input int rmode, input int pmode);
    logic [NB-1:0] wm;
    bit            rq [NB];
    logic [7:0]    cap [SB];
    int            ncap, lastpos, frames, tmo, poke_step, poke_k, k, len_e;
    bit            firstseen, chk_wait, prev_stall, prev_last;
    logic [7:0]    prev_data, rv;
    logic [31:0]   v;
    for (int i = 0; i < NB; i++) rq[i] = 0;
    ncap = 0; lastpos = -1; frames = 0; tmo = 0; poke_step = 0; poke_k = 0;
    firstseen = 0; chk_wait = 0; prev_stall = 0; prev_last = 0; prev_data = '0;
    rtc_in = vts(tseq);
    wm = mask;
    req_wr = 1'b1; req_bits = mask;
    @(negedge clk);
    req_wr = 1'b0;
    while ((wm != '0 || chk_wait) && tmo < 20000) begin
      tmo++;
      sw_wr = 1'b0; req_wr = 1'b0;
      if (chk_wait) begin
        chk(waiting == wm, "R3 waiting after completion", waiting, wm);
        chk_wait = 0;
      end
      if (irq) begin
        k = lowest(wm);
        len_e = eff_len(k);
        chk(int'(last_sent) == k, "R4 R9 order / last_sent", last_sent, k);
        chk(ncap == len_e, "R5 R7 byte count", ncap, len_e);
        if (ncap == len_e)
          for (int i = 0; i < ncap; i++)
            chk(cap[i] == exp_mem[k*SB+8+i], "R5 frame byte", cap[i], exp_mem[k*SB+8+i]);
        chk(lastpos == len_e - 1, "R6 last marker position", lastpos, len_e - 1);
        v = vts(tseq);
        for (int j = 0; j < 4; j++) exp_mem[k*SB+252+j] = 8'(v >> (24 - 8*j));
        tseq++;
        rtc_in = vts(tseq);
        if (rq[k]) rq[k] = 0; else wm[k] = 1'b0;
        chk_wait = 1; ncap = 0; lastpos = -1; firstseen = 0; frames++;
      end
      case (rmode)
        0:       tx_ready = 1'b1;
        1:       tx_ready = tmo[0];
        default: tx_ready = (tmo % 3) != 0;
      endcase
      if (tx_valid) begin
        if (prev_stall)
          chk(tx_data == prev_data && tx_last == prev_last, "R6 hold under stall",
              {tx_last, tx_data}, {prev_last, prev_data});
        if (tx_ready) begin
          cap[ncap] = tx_data;
          if (tx_last) lastpos = ncap;
          ncap++;
          if (!firstseen) begin
            firstseen = 1;
            rtc_in = 32'hDEAD0000 | 32'(tseq);
            if (frames == 0 && pmode == 1) poke_step = 1;
            if (frames == 0 && pmode == 2) begin
              k = lowest(wm);
              req_wr = 1'b1; req_bits = NB'(1) << k; rq[k] = 1;
            end
          end
        end
      end
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      prev_last  = tx_last;
      if (poke_step == 1) begin
        poke_k = lowest(wm);
        sw_wr = 1'b1; sw_addr = AW'(poke_k*SB + 9); sw_wdata = ~exp_mem[poke_k*SB+9];
        poke_step = 2;
      end else if (poke_step == 2) begin
        k = (poke_k + 1) % NB;
        sw_wr = 1'b1; sw_addr = AW'(k*SB + 20); sw_wdata = 8'h77;
        exp_mem[k*SB+20] = 8'h77;
        poke_step = 3;
      end
      @(negedge clk);
    end
    sw_wr = 1'b0; req_wr = 1'b0;
    chk(tmo < 20000, "R3 batch completes", tmo, 20000);
    if (pmode == 1) begin
      sw_read(poke_k*SB + 9, rv);
      chk(rv == exp_mem[poke_k*SB+9], "R10 write to in-flight section dropped", rv, exp_mem[poke_k*SB+9]);
      k = (poke_k + 1) % NB;
      sw_read(k*SB + 20, rv);
      chk(rv == 8'h77, "R10 write to idle section applied", rv, 8'h77);
    end
    if (pmode == 2) chk(frames == 3, "R11 requeued frame sent again", frames, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    lens = '{60, 1, 0, 244, 250, 17, 2, 100};
    rst_n = 1'b0; sw_wr = 0; sw_rd = 0; sw_addr = '0; sw_wdata = '0;
    req_wr = 0; req_bits = '0; rtc_in = '0; tx_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(waiting == '0, "R1 waiting after reset", waiting, 0);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    chk(tx_valid == 1'b0, "R1 tx_valid after reset", tx_valid, 0);

    for (int b = 0; b < NB; b++)
      for (int o = 0; o < SB; o++) begin
        exp_mem[b*SB+o] = (o == 0) ? 8'(lens[b]) : pat(b, o);
        sw_write(b*SB + o, exp_mem[b*SB+o]);
      end
    for (int a = 0; a < NB*SB; a++) begin
      sw_read(a, rv);
      chk(rv == exp_mem[a], "R2 readback", rv, exp_mem[a]);
    end

    // each buffer alone (R5 R6 R7 R8 R9), with three ready patterns
    for (int b = 0; b < NB; b++) run_batch(NB'(1) << b, b % 3, 0);
    // all eight at once: strict ascending order (R4)
    run_batch(8'hFF, 0, 0);
    // mixed mask, alternating ready, writes during flight (R10)
    run_batch(8'hA6, 1, 1);
    // re-request while in flight (R11)
    run_batch(8'h21, 2, 2);

    chk(waiting == '0, "R3 nothing left waiting", waiting, 0);
    // whole memory: stamps (R8) and untouched frames (R10)
    for (int a = 0; a < NB*SB; a++) begin
      sw_read(a, rv);
      chk(rv == exp_mem[a], "R8 R10 final memory image", rv, exp_mem[a]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule